// File: doc/BRIEF.md
# Exception Return and Interrupt-Enable Controller

This block holds the privileged control state that a processor core consults when it leaves a trap or debug handler. It keeps a small status register with an interrupt-enable bit, an exception-level bit, an error-level bit and a two-bit requested privilege field. Beside it sit a debug-mode flag and three return-address registers: one for exceptions, one for error traps and one for debug.

A command port carries one command per cycle. The commands are interrupt disable, interrupt enable, exception return, exception return without dropping the load-linked reservation, and debug return. The disable and enable commands report the status value from before the change. A return command produces a single-cycle redirect strobe together with the target PC. The plain exception return also produces a pulse that clears the load-linked reservation. The effective privilege mode is derived from the stored state at all times. Trap entry logic outside this block loads the return registers, the status register and the debug flag through a plain address/data/write-enable port.

Top module: `excret_ctrl`

## Requirements
- R1: When reset is asserted, status_o reads 0x4: bit 2 (error level) is 1, bit 0 (interrupt enable) is 0, bit 1 (exception level) is 0, and the privilege field in bits 4:3 is 00. At the same time dbg_mode_o is 0, mode_o is 2'b11, and redirect_o, ll_clear_o and old_valid_o are 0. All return registers reset to 0.
- R2: Command code 0 (disable) clears status bit 0 after the next clock edge. In that same cycle old_valid_o pulses and old_status_o shows the status value from before the command.
- R3: Command code 1 (enable) sets status bit 0 after the next clock edge. old_valid_o pulses and old_status_o carries the earlier status value.
- R4: For command codes 2 and 3 with status bit 2 set, the redirect target is the error-return register. Bit 2 is cleared and bit 1 keeps its value.
- R5: For command codes 2 and 3 with status bit 2 clear, the redirect target is the exception-return register and bit 1 is cleared.
- R6: Command code 2 pulses ll_clear_o for one cycle, aligned with redirect_o. Command code 3 leaves ll_clear_o low.
- R7: Command code 4 (debug return) redirects to the debug-return register and clears dbg_mode_o. The status register is left unchanged.
- R8: mode_o is 11 whenever status bit 2 is set. Otherwise it is 00 (kernel) when bit 1 is set or debug mode is active. Otherwise it follows the field in bits 4:3: 00 gives kernel, 01 gives supervisor, 10 gives user, and 11 is treated as kernel.
- R9: redirect_o is high for exactly one cycle per return command, in the cycle after the command is taken, and pc_o carries the target in that cycle. Commands 0 and 1 produce no redirect. Two return commands on consecutive cycles give two consecutive pulses.
- R10: The configuration port decodes cfg_addr_i as follows: 0 is status (bits 4:0), 1 is the exception return, 2 is the error return, 3 is the debug return, and 4 is the debug flag (bit 0). A write takes effect after the next clock edge. The write is ignored in any cycle where cmd_valid_i is high.
- R11: Command codes 5 to 7 change no state and produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | XLEN | Configuration write data |
| redirect_o | output | 1 | One-cycle PC redirect strobe |
| pc_o | output | XLEN | Redirect target |
| ll_clear_o | output | 1 | Load-linked reservation clear pulse |
| old_valid_o | output | 1 | old_status_o valid pulse |
| old_status_o | output | XLEN | Status before a disable/enable command |
| status_o | output | XLEN | Current status register |
| dbg_mode_o | output | 1 | Debug mode flag |
| mode_o | output | 2 | Effective privilege mode |

## Verification
The bench first issues an exception return while both level bits are set. A design that tested the exception-level bit first would jump to the exception address and leave the error level set. It then issues the no-clear return directly after the plain one. Swapped or shared reservation-clear logic would show up as a missing or spurious ll_clear_o pulse. A configuration write is made in the same cycle as a return, and the following return shows whether the return register was overwritten. The bench also sweeps the privilege field, including the reserved value, under the debug flag and the level bits, and issues undefined codes and back-to-back returns. A mode priority error, a stuck redirect or a decoder that acts on stray codes is exposed at the ports.

// File: rtl/excret_pkg.sv
package excret_pkg;
  localparam int STW     = 5;
  localparam int IE_BIT  = 0;
  localparam int EXL_BIT = 1;
  localparam int ERL_BIT = 2;
  localparam int KSU_LO  = 3;
  localparam int NRET    = 3;

  localparam logic [2:0] OP_DI     = 3'd0;
  localparam logic [2:0] OP_EI     = 3'd1;
  localparam logic [2:0] OP_ERET   = 3'd2;
  localparam logic [2:0] OP_ERETNC = 3'd3;
  localparam logic [2:0] OP_DRET   = 3'd4;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_EPC    = 3'd1;
  localparam logic [2:0] A_ERRPC  = 3'd2;
  localparam logic [2:0] A_DPC    = 3'd3;
  localparam logic [2:0] A_DBG    = 3'd4;

  localparam int RI_EPC   = 0;
  localparam int RI_ERRPC = 1;
  localparam int RI_DPC   = 2;

  typedef enum logic [1:0] {
    M_KERN = 2'b00,
    M_SUP  = 2'b01,
    M_USER = 2'b10,
    M_ERR  = 2'b11
  } mode_e;

  localparam logic [STW-1:0] STATUS_RST = STW'(1 << ERL_BIT);
endpackage

// File: rtl/excret_dec.sv
module excret_dec
  import excret_pkg::*;
#(
  parameter int NR = NRET
) (
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  output logic          do_di_o,
  output logic          do_ei_o,
  output logic          do_eret_o,
  output logic          do_ll_o,
  output logic          do_dret_o,
  output logic          wr_status_o,
  output logic          wr_dbg_o,
  output logic [NR-1:0] wr_ret_o
);
  logic cfg_ok;

  always_comb begin
    do_di_o   = cmd_valid_i && (cmd_op_i == OP_DI);
    do_ei_o   = cmd_valid_i && (cmd_op_i == OP_EI);
    do_eret_o = cmd_valid_i && ((cmd_op_i == OP_ERET) || (cmd_op_i == OP_ERETNC));
    do_ll_o   = cmd_valid_i && (cmd_op_i == OP_ERET);
    do_dret_o = cmd_valid_i && (cmd_op_i == OP_DRET);
  end

  // command owns the cycle; config writes yield
  assign cfg_ok      = cfg_we_i && !cmd_valid_i;
  assign wr_status_o = cfg_ok && (cfg_addr_i == A_STATUS);
  assign wr_dbg_o    = cfg_ok && (cfg_addr_i == A_DBG);

  always_comb begin
    wr_ret_o           = '0;
    wr_ret_o[RI_EPC]   = cfg_ok && (cfg_addr_i == A_EPC);
    wr_ret_o[RI_ERRPC] = cfg_ok && (cfg_addr_i == A_ERRPC);
    wr_ret_o[RI_DPC]   = cfg_ok && (cfg_addr_i == A_DPC);
  end
endmodule

// File: rtl/excret_status.sv
module excret_status
  import excret_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           do_di_i,
  input  logic           do_ei_i,
  input  logic           do_eret_i,
  input  logic           do_dret_i,
  input  logic           wr_status_i,
  input  logic           wr_dbg_i,
  input  logic [STW-1:0] wdata_i,
  output logic [STW-1:0] status_o,
  output logic           dbg_o
);
  logic [STW-1:0] st_q, st_d;
  logic           dbg_q, dbg_d;

  always_comb begin
    st_d  = st_q;
    dbg_d = dbg_q;
    if (do_di_i) st_d[IE_BIT] = 1'b0;
    if (do_ei_i) st_d[IE_BIT] = 1'b1;
    if (do_eret_i) begin
      if (st_q[ERL_BIT]) st_d[ERL_BIT] = 1'b0;
      else               st_d[EXL_BIT] = 1'b0;
    end
    if (do_dret_i)   dbg_d = 1'b0;
    if (wr_status_i) st_d  = wdata_i;
    if (wr_dbg_i)    dbg_d = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= STATUS_RST;
      dbg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dbg_q <= dbg_d;
    end
  end

  assign status_o = st_q;
  assign dbg_o    = dbg_q;

  p_dret_keeps_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_dret_i |=> ($stable(st_q) && !dbg_q));
  p_erl_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eret_i && st_q[ERL_BIT]) |=> (!st_q[ERL_BIT] && (st_q[EXL_BIT] == $past(st_q[EXL_BIT]))));
endmodule

// File: rtl/excret_retregs.sv
module excret_retregs #(
  parameter int XLEN = 32,
  parameter int NR   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NR-1:0]   we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] q_o [NR]
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [XLEN-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    r_q <= '0;
      else if (we_i[g]) r_q <= wdata_i;
    end
    assign q_o[g] = r_q;
  end

  p_onehot_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(we_i));
endmodule

// File: rtl/excret_mode.sv
module excret_mode
  import excret_pkg::*;
(
  input  logic [STW-1:0] status_i,
  input  logic           dbg_i,
  output logic [1:0]     mode_o
);
  mode_e m;
  always_comb begin
    if (status_i[ERL_BIT])                 m = M_ERR;
    else if (status_i[EXL_BIT] || dbg_i)   m = M_KERN;
    else begin
      unique case (status_i[KSU_LO +: 2])
        2'b01:   m = M_SUP;
        2'b10:   m = M_USER;
        default: m = M_KERN;
      endcase
    end
  end
  assign mode_o = m;
endmodule

// File: rtl/excret_ctrl.sv
module excret_ctrl
  import excret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_addr_i,
  input  logic [XLEN-1:0] cfg_wdata_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] pc_o,
  output logic            ll_clear_o,
  output logic            old_valid_o,
  output logic [XLEN-1:0] old_status_o,
  output logic [XLEN-1:0] status_o,
  output logic            dbg_mode_o,
  output logic [1:0]      mode_o
);
  localparam int PADW = XLEN - STW;

  logic            do_di, do_ei, do_eret, do_ll, do_dret, wr_status, wr_dbg;
  logic [NRET-1:0] wr_ret;
  logic [STW-1:0]  st;
  logic            dbg;
  logic [XLEN-1:0] ret_q [NRET];
  logic [XLEN-1:0] tgt;
  logic            redir_q, ll_q, oldv_q;
  logic [XLEN-1:0] pc_q, old_q;

  excret_dec #(.NR(NRET)) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .do_di_o     (do_di),
    .do_ei_o     (do_ei),
    .do_eret_o   (do_eret),
    .do_ll_o     (do_ll),
    .do_dret_o   (do_dret),
    .wr_status_o (wr_status),
    .wr_dbg_o    (wr_dbg),
    .wr_ret_o    (wr_ret)
  );

  excret_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .do_di_i     (do_di),
    .do_ei_i     (do_ei),
    .do_eret_i   (do_eret),
    .do_dret_i   (do_dret),
    .wr_status_i (wr_status),
    .wr_dbg_i    (wr_dbg),
    .wdata_i     (cfg_wdata_i[STW-1:0]),
    .status_o    (st),
    .dbg_o       (dbg)
  );

  excret_retregs #(.XLEN(XLEN), .NR(NRET)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ret),
    .wdata_i (cfg_wdata_i),
    .q_o     (ret_q)
  );

  excret_mode u_mode (
    .status_i (st),
    .dbg_i    (dbg),
    .mode_o   (mode_o)
  );

  // error level outranks exception level
  always_comb begin
    if (do_dret)          tgt = ret_q[RI_DPC];
    else if (st[ERL_BIT]) tgt = ret_q[RI_ERRPC];
    else                  tgt = ret_q[RI_EPC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q <= 1'b0;
      ll_q    <= 1'b0;
      oldv_q  <= 1'b0;
      pc_q    <= '0;
      old_q   <= '0;
    end else begin
      redir_q <= do_eret || do_dret;
      ll_q    <= do_ll;
      oldv_q  <= do_di || do_ei;
      if (do_eret || do_dret) pc_q  <= tgt;
      if (do_di || do_ei)     old_q <= {{PADW{1'b0}}, st};
    end
  end

  assign redirect_o   = redir_q;
  assign pc_o         = pc_q;
  assign ll_clear_o   = ll_q;
  assign old_valid_o  = oldv_q;
  assign old_status_o = old_q;
  assign status_o     = {{PADW{1'b0}}, st};
  assign dbg_mode_o   = dbg;

  p_di_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_DI) |=> (!status_o[IE_BIT] && old_valid_o));
  p_ei_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_EI) |=> (status_o[IE_BIT] && old_valid_o));
  p_exl_path_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_eret && !status_o[ERL_BIT]) |=> (!status_o[EXL_BIT] && redirect_o));
  p_ll_plain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_ERET) |=> ll_clear_o);
  p_ll_nc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_ERETNC) |=> !ll_clear_o);
  p_erl_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ERL_BIT] |-> (mode_o == 2'b11));
  p_redirect_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(cmd_valid_i && (cmd_op_i == OP_ERET || cmd_op_i == OP_ERETNC || cmd_op_i == OP_DRET)));
  p_stray_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i > OP_DRET) |=> ($stable(status_o) && !redirect_o && !old_valid_o));
endmodule

// File: tb/excret_ctrl_bench.sv
module excret_ctrl_bench;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cmd_valid_i = 1'b0;
  logic [2:0]      cmd_op_i = '0;
  logic            cfg_we_i = 1'b0;
  logic [2:0]      cfg_addr_i = '0;
  logic [XLEN-1:0] cfg_wdata_i = '0;
  logic            redirect_o, ll_clear_o, old_valid_o, dbg_mode_o;
  logic [XLEN-1:0] pc_o, old_status_o, status_o;
  logic [1:0]      mode_o;

  always #4 clk = ~clk;

  excret_ctrl #(.XLEN(XLEN)) u_excret_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .redirect_o(redirect_o), .pc_o(pc_o), .ll_clear_o(ll_clear_o),
    .old_valid_o(old_valid_o), .old_status_o(old_status_o),
    .status_o(status_o), .dbg_mode_o(dbg_mode_o), .mode_o(mode_o)
  );

  typedef struct {
    string       tag;
    logic        redir;
    logic [31:0] pc;
    logic        ll;
    logic        oldv;
    logic [31:0] old;
    logic [31:0] st;
    logic        dbg;
    logic [1:0]  mode;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // reference state
  logic [4:0]  m_st  = 5'h04;
  logic        m_dbg = 1'b0;
  logic [31:0] m_epc = '0, m_err = '0, m_dpc = '0;

  function automatic logic [1:0] ref_mode(logic [4:0] s, logic d);
    if (s[2])         return 2'b11;
    if (s[1] || d)    return 2'b00;
    if (s[4:3] == 2'b01) return 2'b01;
    if (s[4:3] == 2'b10) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [2:0] op, logic we, logic [2:0] a, logic [31:0] d);
    exp_t e;
    @(negedge clk);
    cmd_valid_i = v; cmd_op_i = op; cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = d;
    e.tag = tag;
    e.redir = v && (op == 3'd2 || op == 3'd3 || op == 3'd4);
    e.ll    = v && (op == 3'd2);
    e.oldv  = v && (op == 3'd0 || op == 3'd1);
    e.old   = {27'd0, m_st};
    e.pc    = '0;
    if (v) begin
      case (op)
        3'd0: m_st[0] = 1'b0;
        3'd1: m_st[0] = 1'b1;
        3'd2, 3'd3: begin
          if (m_st[2]) begin e.pc = m_err; m_st[2] = 1'b0; end
          else         begin e.pc = m_epc; m_st[1] = 1'b0; end
        end
        3'd4: begin e.pc = m_dpc; m_dbg = 1'b0; end
        default: ;
      endcase
    end else if (we) begin
      case (a)
        3'd0: m_st  = d[4:0];
        3'd1: m_epc = d;
        3'd2: m_err = d;
        3'd3: m_dpc = d;
        3'd4: m_dbg = d[0];
        default: ;
      endcase
    end
    e.st   = {27'd0, m_st};
    e.dbg  = m_dbg;
    e.mode = ref_mode(m_st, m_dbg);
    exp_q.push_back(e);
  endtask

  task automatic cmd(string tag, logic [2:0] op);
    step(tag, 1'b1, op, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [31:0] d);
    step(tag, 1'b0, 3'd0, 1'b1, a, d);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 3'd0, 1'b0, 3'd0, 32'd0);
  endtask

  // monitor: outputs sampled 2 ns after the capturing edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.tag, "redirect", {31'd0, redirect_o}, {31'd0, e.redir});
        chk(e.tag, "ll_clear", {31'd0, ll_clear_o}, {31'd0, e.ll});
        chk(e.tag, "old_valid", {31'd0, old_valid_o}, {31'd0, e.oldv});
        chk(e.tag, "status", status_o, e.st);
        chk(e.tag, "dbg", {31'd0, dbg_mode_o}, {31'd0, e.dbg});
        chk(e.tag, "mode", {30'd0, mode_o}, {30'd0, e.mode});
        if (e.redir) chk(e.tag, "pc", pc_o, e.pc);
        if (e.oldv)  chk(e.tag, "old_status", old_status_o, e.old);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #10;
    // R1 reset values
    chk("R1", "status", status_o, 32'h4);
    chk("R1", "mode", {30'd0, mode_o}, 32'd3);
    chk("R1", "dbg", {31'd0, dbg_mode_o}, 32'd0);
    chk("R1", "redirect", {31'd0, redirect_o}, 32'd0);
    chk("R1", "ll_clear", {31'd0, ll_clear_o}, 32'd0);
    chk("R1", "old_valid", {31'd0, old_valid_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle("R1");
    wr("R10", 3'd1, 32'h0000_1000);
    wr("R10", 3'd2, 32'h0000_2000);
    wr("R10", 3'd3, 32'h0000_3000);
    wr("R10", 3'd0, 32'h16);        // user field, EXL and ERL set
    cmd("R4", 3'd2);                // ERL path, EXL stays, LL cleared
    cmd("R5", 3'd3);                // EXL path, no LL clear
    idle("R8");                     // user mode
    cmd("R3", 3'd1);
    cmd("R2", 3'd0);
    cmd("R2", 3'd0);
    wr("R10", 3'd4, 32'h1);         // debug mode forces kernel
    idle("R8");
    cmd("R7", 3'd4);
    idle("R9");
    wr("R8", 3'd0, 32'h08);         // supervisor
    wr("R8", 3'd0, 32'h18);         // reserved field reads as kernel
    wr("R8", 3'd0, 32'h0A);         // EXL forces kernel
    wr("R8", 3'd0, 32'h0E);         // ERL dominates
    wr("R10", 3'd0, 32'h10);
    step("R10", 1'b1, 3'd2, 1'b1, 3'd1, 32'h5555_5555);
    cmd("R10", 3'd3);               // must still return to 0x1000
    cmd("R11", 3'd5);
    cmd("R11", 3'd6);
    cmd("R11", 3'd7);
    wr("R9", 3'd0, 32'h06);
    cmd("R9", 3'd3);
    cmd("R9", 3'd2);
    cmd("R6", 3'd2);
    cmd("R9", 3'd1);
    idle("R9");
    idle("R9");
    while (exp_q.size() > 0) @(posedge clk);
    #10;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule